// File: doc/BRIEF.md
# Split-Line Replacement Tracker

This block follows a cache-line replacement while it is in progress inside one 1-Kbyte physical line. The line is split into 32 sublines of 32 bytes. The outgoing (old) line and the incoming (new) line share the same physical slot while the replacement runs. Each subline carries one of three states, and the cache keeps answering requests for both lines while sublines drain to the write-back buffer and fill data comes in.

A replacement opens with a start command that gives the old tag, the new tag and the critical subline. The tracker then produces one subline order, and both the write-back stream and the fill stream use it. Write-back events free sublines one at a time. A fill is accepted as soon as its target subline is free, so the fill can trail the write-back by a single granule. Lookups return miss, hit-old, hit-new or stall. When every subline holds new data, a one-cycle done pulse tells the directory to commit the new tag. Two independent trackers are instantiated, so two replacements can be in flight at once.

Top module: `split_line_tracker`

## Requirements
- R1: A start command on an idle tracker captures the old tag, new tag and critical subline, marks all 32 sublines old (state code 1; invalid is 0, new is 2) and raises busy in the next cycle.
- R2: An accepted write-back event marks the subline shown on the write-back index output invalid. A lookup of the old tag on that subline then returns stall.
- R3: A fill event is accepted only while fill-ready is high, which means the fill target subline is invalid. An accepted fill marks that subline new, and a lookup of the new tag on it then returns hit-new.
- R4: A lookup of the old tag on a subline that is still old returns hit-old.
- R5: Lookup result codes are 0 miss, 1 hit-old, 2 hit-new and 3 stall. A tag that matches the old or new tag on a subline in the wrong state returns stall. A tag that matches neither returns miss. Every lookup on an idle tracker returns miss.
- R6: Step k (0..31) of the order visits quarter (cq + k/8) mod 4, where cq is bits 4:3 of the critical subline. In the first quarter the subline offset is (critical offset + k mod 8) mod 8. In the later quarters it is k mod 8. The write-back and fill sequences both follow this order.
- R7: Fill-ready is low while the fill target has not yet been written back. A fill event while not ready changes nothing, and the fill count never passes the write-back count.
- R8: The clock edge that accepts the 32nd fill makes done high for exactly one cycle and returns the tracker to idle.
- R9: A start command while busy is ignored, and the captured tags are kept.
- R10: The two trackers are independent. Activity on one leaves the busy state and lookups of the other unchanged.
- R11: After 32 write-back events, write-back-ready is low and further write-back events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | TRK_N | Start command per tracker |
| old_tag_i | input | TRK_N x TAG_W | Tag of the outgoing line |
| new_tag_i | input | TRK_N x TAG_W | Tag of the incoming line |
| crit_i | input | TRK_N x SUB_W | Critical subline index |
| wb_i | input | TRK_N | Subline moved to write-back buffer |
| wb_rdy_o | output | TRK_N | A subline remains to be written back |
| wb_sub_o | output | TRK_N x SUB_W | Next subline to write back |
| fill_i | input | TRK_N | Fill granule written |
| fill_rdy_o | output | TRK_N | Fill target subline is free |
| fill_sub_o | output | TRK_N x SUB_W | Next subline to fill |
| lk_tag_i | input | TRK_N x TAG_W | Lookup tag |
| lk_sub_i | input | TRK_N x SUB_W | Lookup subline |
| lk_res_o | output | TRK_N x 2 | Lookup result code |
| busy_o | output | TRK_N | Replacement in progress |
| done_o | output | TRK_N | One-cycle completion pulse |

## Verification
The bench sweeps all 32 critical sublines and alternates between the two trackers. For each run it computes the expected visit order, so a design that wraps the critical quarter wrongly, or that starts a later quarter at the critical offset, produces a wrong index. At the midpoint of each run it looks up both tags on every subline. A design that confuses states would return hits on invalid or mismatched sublines instead of stall. Fills issued before any write-back and starts issued while busy are checked through lookups: a design that takes the fill would expose new data too early, and one that takes the start would lose the old tag. The bench also checks that done is a single pulse and that write-back-ready drops after the 32nd write-back.

// File: rtl/sline_pkg.sv
package sline_pkg;
  typedef enum logic [1:0] {
    SS_INV = 2'd0,
    SS_OLD = 2'd1,
    SS_NEW = 2'd2
  } sub_state_e;

  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_HIT_OLD = 2'd1,
    LK_HIT_NEW = 2'd2,
    LK_STALL   = 2'd3
  } lk_res_e;
endpackage

// File: rtl/sline_order.sv
// Maps step index to subline: critical quarter first (wrapped), then ascending quarters.
module sline_order #(
  parameter int unsigned SUB_N = 32,
  parameter int unsigned QTR_N = 4,
  localparam int unsigned SUB_W = $clog2(SUB_N)
) (
  input  logic [SUB_W-1:0] crit_i,
  input  logic [SUB_W-1:0] idx_i,
  output logic [SUB_W-1:0] sub_o
);
  localparam int unsigned QS   = SUB_N / QTR_N;
  localparam int unsigned QS_W = $clog2(QS);
  localparam int unsigned Q_W  = $clog2(QTR_N);

  logic [Q_W-1:0]  crit_q, step_q, qtr;
  logic [QS_W-1:0] crit_off, pos, off;

  always_comb begin
    crit_q   = crit_i[QS_W +: Q_W];
    crit_off = crit_i[QS_W-1:0];
    step_q   = idx_i[QS_W +: Q_W];
    pos      = idx_i[QS_W-1:0];
    qtr      = crit_q + step_q;
    off      = (step_q == '0) ? QS_W'(crit_off + pos) : pos;
    sub_o    = {qtr, off};
  end

  // R6: step zero is always the critical subline
  always_comb begin
    if (idx_i == '0) begin
      p_first_is_crit_r6: assert (sub_o == crit_i);
    end
  end
endmodule

// File: rtl/sline_lookup.sv
module sline_lookup
  import sline_pkg::*;
#(
  parameter int unsigned TAG_W = 11
) (
  input  logic             busy_i,
  input  logic [TAG_W-1:0] old_tag_i,
  input  logic [TAG_W-1:0] new_tag_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  sub_state_e       st_i,
  output lk_res_e          lk_res_o
);
  logic old_m, new_m;

  always_comb begin
    old_m = busy_i && (lk_tag_i == old_tag_i);
    new_m = busy_i && (lk_tag_i == new_tag_i);
    if (old_m)      lk_res_o = (st_i == SS_OLD) ? LK_HIT_OLD : LK_STALL;
    else if (new_m) lk_res_o = (st_i == SS_NEW) ? LK_HIT_NEW : LK_STALL;
    else            lk_res_o = LK_MISS;
  end
endmodule

// File: rtl/sline_tracker.sv
module sline_tracker
  import sline_pkg::*;
#(
  parameter int unsigned SUB_N = 32,
  parameter int unsigned QTR_N = 4,
  parameter int unsigned TAG_W = 11,
  localparam int unsigned SUB_W = $clog2(SUB_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] old_tag_i,
  input  logic [TAG_W-1:0] new_tag_i,
  input  logic [SUB_W-1:0] crit_i,
  input  logic             wb_i,
  output logic             wb_rdy_o,
  output logic [SUB_W-1:0] wb_sub_o,
  input  logic             fill_i,
  output logic             fill_rdy_o,
  output logic [SUB_W-1:0] fill_sub_o,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [SUB_W-1:0] lk_sub_i,
  output logic [1:0]       lk_res_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(SUB_N + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUB_N - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SUB_N);

  logic             busy_q, done_q;
  logic [TAG_W-1:0] old_tag_q, new_tag_q;
  logic [SUB_W-1:0] crit_q;
  logic [CNT_W-1:0] wb_cnt_q, fill_cnt_q;
  sub_state_e       state_q [SUB_N];

  logic start_acc, wb_acc, fill_acc, fill_last;
  lk_res_e lk_res;

  sline_order #(.SUB_N(SUB_N), .QTR_N(QTR_N)) i_wb_order (
    .crit_i(crit_q), .idx_i(wb_cnt_q[SUB_W-1:0]), .sub_o(wb_sub_o)
  );

  sline_order #(.SUB_N(SUB_N), .QTR_N(QTR_N)) i_fill_order (
    .crit_i(crit_q), .idx_i(fill_cnt_q[SUB_W-1:0]), .sub_o(fill_sub_o)
  );

  always_comb begin
    start_acc  = start_i && !busy_q;
    wb_rdy_o   = busy_q && (wb_cnt_q != CNT_FULL);
    wb_acc     = wb_i && wb_rdy_o;
    fill_rdy_o = busy_q && (fill_cnt_q != CNT_FULL) && (state_q[fill_sub_o] == SS_INV);
    fill_acc   = fill_i && fill_rdy_o;
    fill_last  = fill_acc && (fill_cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      old_tag_q  <= '0;
      new_tag_q  <= '0;
      crit_q     <= '0;
      wb_cnt_q   <= '0;
      fill_cnt_q <= '0;
    end else begin
      done_q <= fill_last;
      if (start_acc) begin
        busy_q     <= 1'b1;
        old_tag_q  <= old_tag_i;
        new_tag_q  <= new_tag_i;
        crit_q     <= crit_i;
        wb_cnt_q   <= '0;
        fill_cnt_q <= '0;
      end else begin
        if (wb_acc)    wb_cnt_q   <= wb_cnt_q + 1'b1;
        if (fill_acc)  fill_cnt_q <= fill_cnt_q + 1'b1;
        if (fill_last) busy_q     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SUB_N); i++) state_q[i] <= SS_INV;
    end else if (start_acc) begin
      for (int i = 0; i < int'(SUB_N); i++) state_q[i] <= SS_OLD;
    end else begin
      if (wb_acc)   state_q[wb_sub_o]   <= SS_INV;
      if (fill_acc) state_q[fill_sub_o] <= SS_NEW;
    end
  end

  sline_lookup #(.TAG_W(TAG_W)) i_lookup (
    .busy_i(busy_q), .old_tag_i(old_tag_q), .new_tag_i(new_tag_q),
    .lk_tag_i(lk_tag_i), .st_i(state_q[lk_sub_i]), .lk_res_o(lk_res)
  );

  assign lk_res_o = lk_res;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  p_fill_behind_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> fill_cnt_q <= wb_cnt_q);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_wb_sets_inv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_acc |=> state_q[$past(wb_sub_o)] == SS_INV);
  p_fill_sets_new_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_acc |=> state_q[$past(fill_sub_o)] == SS_NEW);
  p_busy_keeps_tags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(old_tag_q) && $stable(new_tag_q));
  p_idle_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> lk_res_o == 2'd0);
  p_wb_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wb_cnt_q == CNT_FULL) |-> !wb_rdy_o);
endmodule

// File: rtl/split_line_tracker.sv
module split_line_tracker #(
  parameter int unsigned SUB_N = 32,
  parameter int unsigned QTR_N = 4,
  parameter int unsigned TAG_W = 11,
  parameter int unsigned TRK_N = 2,
  localparam int unsigned SUB_W = $clog2(SUB_N)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [TRK_N-1:0]            start_i,
  input  logic [TRK_N-1:0][TAG_W-1:0] old_tag_i,
  input  logic [TRK_N-1:0][TAG_W-1:0] new_tag_i,
  input  logic [TRK_N-1:0][SUB_W-1:0] crit_i,
  input  logic [TRK_N-1:0]            wb_i,
  output logic [TRK_N-1:0]            wb_rdy_o,
  output logic [TRK_N-1:0][SUB_W-1:0] wb_sub_o,
  input  logic [TRK_N-1:0]            fill_i,
  output logic [TRK_N-1:0]            fill_rdy_o,
  output logic [TRK_N-1:0][SUB_W-1:0] fill_sub_o,
  input  logic [TRK_N-1:0][TAG_W-1:0] lk_tag_i,
  input  logic [TRK_N-1:0][SUB_W-1:0] lk_sub_i,
  output logic [TRK_N-1:0][1:0]       lk_res_o,
  output logic [TRK_N-1:0]            busy_o,
  output logic [TRK_N-1:0]            done_o
);
  for (genvar t = 0; t < int'(TRK_N); t++) begin : g_trk
    sline_tracker #(.SUB_N(SUB_N), .QTR_N(QTR_N), .TAG_W(TAG_W)) i_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i[t]),
      .old_tag_i  (old_tag_i[t]),
      .new_tag_i  (new_tag_i[t]),
      .crit_i     (crit_i[t]),
      .wb_i       (wb_i[t]),
      .wb_rdy_o   (wb_rdy_o[t]),
      .wb_sub_o   (wb_sub_o[t]),
      .fill_i     (fill_i[t]),
      .fill_rdy_o (fill_rdy_o[t]),
      .fill_sub_o (fill_sub_o[t]),
      .lk_tag_i   (lk_tag_i[t]),
      .lk_sub_i   (lk_sub_i[t]),
      .lk_res_o   (lk_res_o[t]),
      .busy_o     (busy_o[t]),
      .done_o     (done_o[t])
    );
  end
endmodule

// File: tb/test_split_line_tracker.sv
module test_split_line_tracker;
  localparam int TRK_N = 2;
  localparam int TAG_W = 11;
  localparam int SUB_W = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [TRK_N-1:0]            start_i = '0, wb_i = '0, fill_i = '0;
  logic [TRK_N-1:0][TAG_W-1:0] old_tag_i = '0, new_tag_i = '0, lk_tag_i = '0;
  logic [TRK_N-1:0][SUB_W-1:0] crit_i = '0, lk_sub_i = '0;
  logic [TRK_N-1:0]            wb_rdy_o, fill_rdy_o, busy_o, done_o;
  logic [TRK_N-1:0][SUB_W-1:0] wb_sub_o, fill_sub_o;
  logic [TRK_N-1:0][1:0]       lk_res_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  split_line_tracker i_split_line_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .old_tag_i(old_tag_i),
    .new_tag_i(new_tag_i), .crit_i(crit_i), .wb_i(wb_i), .wb_rdy_o(wb_rdy_o),
    .wb_sub_o(wb_sub_o), .fill_i(fill_i), .fill_rdy_o(fill_rdy_o),
    .fill_sub_o(fill_sub_o), .lk_tag_i(lk_tag_i), .lk_sub_i(lk_sub_i),
    .lk_res_o(lk_res_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic int ord(int c, int k);
    int q = ((c / 8) + (k / 8)) % 4;
    if (k / 8 == 0) return q * 8 + ((c % 8) + (k % 8)) % 8;
    return q * 8 + (k % 8);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(int t, logic [TAG_W-1:0] tag, int sub, output int res);
    lk_tag_i[t] = tag;
    lk_sub_i[t] = SUB_W'(sub);
    #1;
    res = int'(lk_res_o[t]);
  endtask

  task automatic run(int t, int c);
    logic [TAG_W-1:0] ot, nt, xt;
    int r, u;
    u = 1 - t;
    ot = TAG_W'((c * 37 + t * 5 + 3) & 'h3FF);
    nt = ot | 11'h400;
    xt = ot ^ 11'h155;
    @(negedge clk);
    old_tag_i[t] = ot; new_tag_i[t] = nt; crit_i[t] = SUB_W'(c); start_i[t] = 1'b1;
    @(negedge clk);
    start_i[t] = 1'b0;
    chk("R1 busy after start", int'(busy_o[t]), 1);
    look(t, ot, c, r);  chk("R4 old tag on old subline", r, 1);
    look(t, nt, c, r);  chk("R5 new tag on old subline stalls", r, 3);
    look(t, xt, c, r);  chk("R5 unrelated tag misses", r, 0);
    chk("R7 fill not ready before write-back", int'(fill_rdy_o[t]), 0);
    chk("R10 other tracker idle", int'(busy_o[u]), 0);
    look(u, ot, c, r);  chk("R10 other tracker misses", r, 0);
    // R7: early fill ignored
    fill_i[t] = 1'b1;
    @(negedge clk);
    fill_i[t] = 1'b0;
    chk("R7 fill index unchanged", int'(fill_sub_o[t]), ord(c, 0));
    look(t, ot, c, r);  chk("R7 early fill left old data", r, 1);
    // R9: start while busy ignored
    old_tag_i[t] = xt; new_tag_i[t] = xt; crit_i[t] = SUB_W'(c ^ 5); start_i[t] = 1'b1;
    @(negedge clk);
    start_i[t] = 1'b0;
    look(t, ot, c, r);  chk("R9 old tag kept", r, 1);
    look(t, xt, c, r);  chk("R9 restart tag not taken", r, 0);
    chk("R9 order kept", int'(wb_sub_o[t]), ord(c, 0));
    for (int k = 0; k < 32; k++) begin
      chk("R6 write-back order", int'(wb_sub_o[t]), ord(c, k));
      chk("R11 write-back ready", int'(wb_rdy_o[t]), 1);
      wb_i[t] = 1'b1;
      @(negedge clk);
      wb_i[t] = 1'b0;
      look(t, ot, ord(c, k), r); chk("R2 written-back subline stalls", r, 3);
      look(t, nt, ord(c, k), r); chk("R5 new tag on invalid stalls", r, 3);
      chk("R6 fill order", int'(fill_sub_o[t]), ord(c, k));
      chk("R3 fill ready on invalid", int'(fill_rdy_o[t]), 1);
      if (k == 31) begin
        chk("R11 write-back ready drops", int'(wb_rdy_o[t]), 0);
        wb_i[t] = 1'b1;
        @(negedge clk);
        wb_i[t] = 1'b0;
        chk("R11 extra write-back ignored", int'(busy_o[t]), 1);
        chk("R11 fill index kept", int'(fill_sub_o[t]), ord(c, 31));
      end
      fill_i[t] = 1'b1;
      @(negedge clk);
      fill_i[t] = 1'b0;
      if (k < 31) begin
        look(t, nt, ord(c, k), r); chk("R3 filled subline hits new", r, 2);
        look(t, ot, ord(c, k), r); chk("R5 old tag on new stalls", r, 3);
        chk("R7 fill waits for write-back", int'(fill_rdy_o[t]), 0);
        chk("R8 no early done", int'(done_o[t]), 0);
      end
      if (k == 15) begin
        for (int j = 0; j < 32; j++) begin
          look(t, ot, ord(c, j), r); chk("R4 sweep old tag", r, (j <= 15) ? 3 : 1);
          look(t, nt, ord(c, j), r); chk("R3 sweep new tag", r, (j <= 15) ? 2 : 3);
        end
      end
    end
    chk("R8 done pulse", int'(done_o[t]), 1);
    chk("R8 idle after done", int'(busy_o[t]), 0);
    look(t, nt, c, r); chk("R5 idle lookup misses", r, 0);
    @(negedge clk);
    chk("R8 done lasts one cycle", int'(done_o[t]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R8 reset done", int'(done_o), 0);
    look(0, '0, 0, r); chk("R5 reset lookup miss", r, 0);
    rst_ni = 1'b1;
    for (int c = 0; c < 32; c++) run(c % 2, c);
    for (int c = 0; c < 32; c += 7) run(1 - (c % 2), c);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule